// File: doc/BRIEF.md
# Debug Trigger Address/Data Comparator Bank

This block holds the comparison logic for a small bank of debug triggers of the address/data kind. Each cycle a core presents one item: a load or store address, load or store data, a fetch address, or an instruction opcode. The item comes with its access kind and the current privilege level. Every trigger compares the item with its own compare value. The comparison follows the trigger's 4-bit match code, and it counts only when the trigger's access-kind enables, privilege enables and address/data select allow it. The result is a per-trigger local hit.

Triggers can be linked into chains. A chain trips only when every member has a local hit. The action to take comes from the last member of the tripped chain. If several chains trip, the lowest-numbered chain supplies the action.

The control words are supplied from outside, because register storage lives elsewhere. The block does keep each trigger's compare value. Whenever that value is written, the block precomputes a naturally aligned power-of-two (NAPOT) mask so that the compare path stays short. Results are registered and appear one clock after the request.

Top module: `trig_match_bank`

## Requirements
- R1: After a synchronous active-low reset, local_hit_o, trip_o, act_vld_o and act_o are zero, and every compare value is zero.
- R2: Match code 0 hits when the item equals the compare value. Code 8 hits when they differ.
- R3: Match code 1 compares only the item bits above position t, where t is the number of trailing ones in the compare value. The mask is all ones shifted left by t+1. Code 9 is the negation of code 1.
- R4: When the compare value has at least XLEN-1 trailing ones, the mask is zero and code 1 hits on every item.
- R5: Match code 2 hits when the item is greater than or equal to the compare value, and code 3 hits when the item is less than it. Both comparisons are unsigned.
- R6: Code 4 hits when (item low half AND compare high half) equals the compare low half. Code 5 does the same test using the item high half. Codes 12 and 13 negate codes 4 and 5.
- R7: Control bits 0, 1 and 2 enable load (kind 0), store (kind 1) and execute (kind 2) respectively. Kind 3 never hits. The select bit (bit 19 for type 2, bit 21 for type 6; 1 means data or opcode) must equal req_is_data_i.
- R8: Control bits 3, 4 and 6 enable user (priv 0), supervisor (priv 1) and machine (priv 3) level. Priv 2 never hits.
- R9: Only type 2 and type 6 (control bits XLEN-1..XLEN-4) can hit. Type 0, type 15 and all other types never produce a local hit.
- R10: Control bit 11 links trigger i to trigger i+1, and the chain bit of the last trigger is ignored. A trigger's trip_o bit is set only when every member of its chain has a local hit.
- R11: act_vld_o is set when any chain trips. act_o then holds the action field (control bits 15..12) of the last member of the lowest-numbered tripped chain.
- R12: If a type-6 trigger's compare value is written as all ones, the stored value is the NAPOT_MAX parameter instead. A type-2 trigger stores all ones unchanged.
- R13: Outputs reflect the request of the previous clock. A cycle with req_valid_i low yields all-zero outputs on the next clock.
- R14: Match codes 6, 7, 10, 11, 14 and 15 never hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl_i | input | NUM_TRIG*XLEN | Control word of each trigger, trigger i at bits i*XLEN |
| cmp_we_i | input | NUM_TRIG | Per-trigger compare value write strobe |
| cmp_wdata_i | input | XLEN | Compare value write data |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 execute |
| req_priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_is_data_i | input | 1 | Item is data/opcode (1) or address (0) |
| req_item_i | input | XLEN | Item to compare |
| local_hit_o | output | NUM_TRIG | Registered per-trigger local hit |
| trip_o | output | NUM_TRIG | Registered per-trigger chain trip |
| act_vld_o | output | 1 | Some chain tripped |
| act_o | output | 4 | Action of the selected tripped chain |

## Verification
The bench targets the mask corners. These are a compare value with 31 trailing ones, which must match everything; all ones written to a type-6 trigger, which must be replaced so that bit 31 is still compared; and a reset value whose mask ignores only bit 0. A design that miscounts trailing ones, or that forgets the zero-mask case, reports misses where hits are due. The bench checks the unsigned ordering with items on either side of 0x8000_0000, where a signed compare inverts the result. It checks the half-word modes with items whose halves differ, which exposes a swapped half. It checks chains where only one member hits, where a wrongly computed chain trips. It checks two chains tripping at once, where a wrong priority or a wrong "last member" gives the wrong action.

// File: rtl/trig_pkg.sv
// Shared definitions for the trigger comparator bank.
// Assumes control words follow the field positions below; the type field
// occupies the top four bits of each control word.
package trig_pkg;

    localparam int BIT_LOAD   = 0;
    localparam int BIT_STORE  = 1;
    localparam int BIT_EXEC   = 2;
    localparam int BIT_USER   = 3;
    localparam int BIT_SUPER  = 4;
    localparam int BIT_MACH   = 6;
    localparam int MATCH_LSB  = 7;
    localparam int MATCH_W    = 4;
    localparam int BIT_CHAIN  = 11;
    localparam int ACT_LSB    = 12;
    localparam int ACT_W      = 4;
    localparam int SEL_T2_BIT = 19;
    localparam int SEL_T6_BIT = 21;
    localparam int TYPE_W     = 4;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_NONE  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [3:0] {
        MC_EQ      = 4'd0,
        MC_NAPOT   = 4'd1,
        MC_GE      = 4'd2,
        MC_LT      = 4'd3,
        MC_HI_LO   = 4'd4,
        MC_LO_HI   = 4'd5,
        MC_NEQ     = 4'd8,
        MC_NNAPOT  = 4'd9,
        MC_NHI_LO  = 4'd12,
        MC_NLO_HI  = 4'd13
    } match_code_e;

    localparam logic [3:0] TYPE_ADDR_DATA  = 4'd2;
    localparam logic [3:0] TYPE_ADDR_DATA6 = 4'd6;

endpackage

// File: rtl/trig_value_reg.sv
// Compare value holder for one trigger.
// Stores the compare value and precomputes its NAPOT mask at write time so
// the match path sees a ready mask. A type-6 trigger written with all ones
// stores NAPOT_MAX instead. Assumes one write strobe per trigger.
module trig_value_reg #(
    parameter int               XLEN      = 32,
    parameter logic [XLEN-1:0]  NAPOT_MAX = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    input  logic            is_type6,
    output logic [XLEN-1:0] cval,
    output logic [XLEN-1:0] cmask
);

    // Mask with ones strictly above the run of trailing ones of v.
    function automatic logic [XLEN-1:0] napot_mask(input logic [XLEN-1:0] v);
        int unsigned ones;
        logic        stopped;
        ones    = 0;
        stopped = 1'b0;
        for (int j = 0; j < XLEN; j++) begin
            if (!stopped && v[j]) ones++;
            else                  stopped = 1'b1;
        end
        if (ones >= XLEN - 1) return '0;
        return {XLEN{1'b1}} << (ones + 1);
    endfunction

    logic [XLEN-1:0] wval;

    // Select the value to store, applying the type-6 all-ones substitution.
    always_comb begin
        wval = wdata;
        if (is_type6 && (&wdata)) wval = NAPOT_MAX;
    end

    // Hold compare value and its mask; both update together on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cval  <= '0;
            cmask <= napot_mask('0);
        end else if (we) begin
            cval  <= wval;
            cmask <= napot_mask(wval);
        end
    end

endmodule

// File: rtl/trig_cmp_unit.sv
// Match evaluator for one trigger (combinational).
// Applies the match code to the item and compare value, and qualifies the
// result by trigger type, access kind, privilege level and address/data
// select. Assumes XLEN is even so the half-word modes split evenly.
module trig_cmp_unit
    import trig_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            valid,
    input  logic [XLEN-1:0] ctrl,
    input  logic [XLEN-1:0] cval,
    input  logic [XLEN-1:0] cmask,
    input  logic [XLEN-1:0] item,
    input  logic [1:0]      kind,
    input  logic [1:0]      priv,
    input  logic            is_data,
    output logic            hit
);

    localparam int HALF = XLEN / 2;

    logic [TYPE_W-1:0]  typ;
    logic [MATCH_W-1:0] code;
    logic               is_ad;
    logic               sel;
    logic               kind_ok;
    logic               priv_ok;
    logic               raw;
    logic               known;
    logic               cond;
    logic               eq_full;
    logic               eq_masked;
    logic               ge_u;
    logic               half_lo;
    logic               half_hi;

    assign typ  = ctrl[XLEN-1 -: TYPE_W];
    assign code = ctrl[MATCH_LSB +: MATCH_W];

    // Decode the trigger type and the position of its select bit.
    always_comb begin
        is_ad = (typ == TYPE_ADDR_DATA) || (typ == TYPE_ADDR_DATA6);
        sel   = (typ == TYPE_ADDR_DATA6) ? ctrl[SEL_T6_BIT] : ctrl[SEL_T2_BIT];
    end

    // Access-kind enable lookup.
    always_comb begin
        unique case (kind)
            KIND_LOAD:  kind_ok = ctrl[BIT_LOAD];
            KIND_STORE: kind_ok = ctrl[BIT_STORE];
            KIND_EXEC:  kind_ok = ctrl[BIT_EXEC];
            default:    kind_ok = 1'b0;
        endcase
    end

    // Privilege enable lookup.
    always_comb begin
        unique case (priv)
            PRV_USER:  priv_ok = ctrl[BIT_USER];
            PRV_SUPER: priv_ok = ctrl[BIT_SUPER];
            PRV_MACH:  priv_ok = ctrl[BIT_MACH];
            default:   priv_ok = 1'b0;
        endcase
    end

    // Elementary comparisons shared by the positive and negated codes.
    always_comb begin
        eq_full   = (item == cval);
        eq_masked = ((item & cmask) == (cval & cmask));
        ge_u      = (item >= cval);
        half_lo   = ((item[HALF-1:0]    & cval[XLEN-1:HALF]) == cval[HALF-1:0]);
        half_hi   = ((item[XLEN-1:HALF] & cval[XLEN-1:HALF]) == cval[HALF-1:0]);
    end

    // Select the comparison by match code; undefined codes never hit.
    always_comb begin
        known = 1'b1;
        raw   = 1'b0;
        case (code)
            MC_EQ,    MC_NEQ:    raw = eq_full;
            MC_NAPOT, MC_NNAPOT: raw = eq_masked;
            MC_GE:               raw = ge_u;
            MC_LT:               raw = !ge_u;
            MC_HI_LO, MC_NHI_LO: raw = half_lo;
            MC_LO_HI, MC_NLO_HI: raw = half_hi;
            default:             known = 1'b0;
        endcase
        cond = known && (raw ^ code[3]);
    end

    // Combine comparison with all qualifiers.
    always_comb begin
        hit = valid && is_ad && kind_ok && priv_ok && (sel == is_data) && cond;
    end

endmodule

// File: rtl/trig_chain_unit.sv
// Chain resolver (combinational).
// A chain is a run of triggers linked by chain bits; trigger i links to
// i+1, and the last trigger's chain bit is ignored. Every member trips only
// if all members hit. The action comes from the last member of the
// lowest-numbered tripped chain.
module trig_chain_unit #(
    parameter int NUM_TRIG = 4,
    parameter int ACT_W    = 4
) (
    input  logic [NUM_TRIG-1:0]       lhit,
    input  logic [NUM_TRIG-1:0]       chain,
    input  logic [NUM_TRIG*ACT_W-1:0] actions,
    output logic [NUM_TRIG-1:0]       trip,
    output logic                      act_vld,
    output logic [ACT_W-1:0]          act
);

    logic [NUM_TRIG-1:0] link;
    logic [NUM_TRIG-1:0] fwd;
    logic [NUM_TRIG-1:0] bwd;
    logic [NUM_TRIG-1:0] tail;

    genvar i;
    generate
        for (i = 0; i < NUM_TRIG; i++) begin : g_link
            if (i == NUM_TRIG - 1) begin : g_last
                assign link[i] = 1'b0;
            end else begin : g_mid
                assign link[i] = chain[i];
            end
        end

        // Forward AND: all members from the chain head up to i hit.
        for (i = 0; i < NUM_TRIG; i++) begin : g_fwd
            if (i == 0) begin : g_head
                assign fwd[i] = lhit[i];
            end else begin : g_rest
                assign fwd[i] = lhit[i] && (!link[i-1] || fwd[i-1]);
            end
        end

        // Backward AND: all members from i down to the chain tail hit.
        for (i = NUM_TRIG - 1; i >= 0; i--) begin : g_bwd
            if (i == NUM_TRIG - 1) begin : g_tail
                assign bwd[i] = lhit[i];
            end else begin : g_rest
                assign bwd[i] = lhit[i] && (!link[i] || bwd[i+1]);
            end
        end
    endgenerate

    // A trigger trips when its whole chain hits on both sides of it.
    always_comb begin
        trip = fwd & bwd;
        tail = trip & ~link;
    end

    // Pick the action of the lowest tripped chain's tail.
    always_comb begin
        act_vld = |tail;
        act     = '0;
        for (int k = NUM_TRIG - 1; k >= 0; k--) begin
            if (tail[k]) act = actions[k*ACT_W +: ACT_W];
        end
    end

endmodule

// File: rtl/trig_match_bank.sv
// Debug trigger comparator bank (top).
// Holds compare values, evaluates every trigger against the presented item,
// resolves chains and registers the results one clock after the request.
// Control words are supplied by the surrounding register file.
module trig_match_bank
    import trig_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              NUM_TRIG  = 4,
    parameter logic [XLEN-1:0] NAPOT_MAX = ~({{(XLEN-1){1'b0}}, 1'b1} << (XLEN - 2))
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_TRIG*XLEN-1:0] cfg_ctrl_i,
    input  logic [NUM_TRIG-1:0]      cmp_we_i,
    input  logic [XLEN-1:0]          cmp_wdata_i,
    input  logic                     req_valid_i,
    input  logic [1:0]               req_kind_i,
    input  logic [1:0]               req_priv_i,
    input  logic                     req_is_data_i,
    input  logic [XLEN-1:0]          req_item_i,
    output logic [NUM_TRIG-1:0]      local_hit_o,
    output logic [NUM_TRIG-1:0]      trip_o,
    output logic                     act_vld_o,
    output logic [ACT_W-1:0]         act_o
);

    logic [NUM_TRIG-1:0]       lhit;
    logic [NUM_TRIG-1:0]       chain_bits;
    logic [NUM_TRIG*ACT_W-1:0] act_bits;
    logic [NUM_TRIG-1:0]       trip_c;
    logic                      act_vld_c;
    logic [ACT_W-1:0]          act_c;

    genvar t;
    generate
        for (t = 0; t < NUM_TRIG; t++) begin : g_trig
            logic [XLEN-1:0] ctrl;
            logic [XLEN-1:0] cval;
            logic [XLEN-1:0] cmask;

            assign ctrl                       = cfg_ctrl_i[t*XLEN +: XLEN];
            assign chain_bits[t]              = ctrl[BIT_CHAIN];
            assign act_bits[t*ACT_W +: ACT_W] = ctrl[ACT_LSB +: ACT_W];

            trig_value_reg #(
                .XLEN      (XLEN),
                .NAPOT_MAX (NAPOT_MAX)
            ) u_val (
                .clk      (clk),
                .rst_n    (rst_n),
                .we       (cmp_we_i[t]),
                .wdata    (cmp_wdata_i),
                .is_type6 (ctrl[XLEN-1 -: TYPE_W] == TYPE_ADDR_DATA6),
                .cval     (cval),
                .cmask    (cmask)
            );

            trig_cmp_unit #(
                .XLEN (XLEN)
            ) u_cmp (
                .valid   (req_valid_i),
                .ctrl    (ctrl),
                .cval    (cval),
                .cmask   (cmask),
                .item    (req_item_i),
                .kind    (req_kind_i),
                .priv    (req_priv_i),
                .is_data (req_is_data_i),
                .hit     (lhit[t])
            );
        end
    endgenerate

    trig_chain_unit #(
        .NUM_TRIG (NUM_TRIG),
        .ACT_W    (ACT_W)
    ) u_chain (
        .lhit    (lhit),
        .chain   (chain_bits),
        .actions (act_bits),
        .trip    (trip_c),
        .act_vld (act_vld_c),
        .act     (act_c)
    );

    // Register the per-request results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_hit_o <= '0;
            trip_o      <= '0;
            act_vld_o   <= 1'b0;
            act_o       <= '0;
        end else begin
            local_hit_o <= lhit;
            trip_o      <= trip_c;
            act_vld_o   <= act_vld_c;
            act_o       <= act_c;
        end
    end

endmodule

// File: rtl/trig_match_bank_chk.sv
// Property checker for the trigger comparator bank, bound to the top.
// Observes only the top-level ports.
module trig_match_bank_chk #(
    parameter int NUM_TRIG = 4,
    parameter int ACT_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid_i,
    input logic [1:0]          req_kind_i,
    input logic [1:0]          req_priv_i,
    input logic [NUM_TRIG-1:0] local_hit_o,
    input logic [NUM_TRIG-1:0] trip_o,
    input logic                act_vld_o,
    input logic [ACT_W-1:0]    act_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (local_hit_o == '0 && trip_o == '0 && !act_vld_o && act_o == '0));

    assert_trip_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o & ~local_hit_o) == '0);

    assert_act_vld_tracks_trip_R11: assert property (@(posedge clk) disable iff (!rst_n)
        act_vld_o == (trip_o != '0));

    assert_rsvd_priv_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_priv_i == 2'd2) |=> (local_hit_o == '0));

    assert_no_kind_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i == 2'd3) |=> (local_hit_o == '0));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (local_hit_o == '0 && !act_vld_o));

endmodule

bind trig_match_bank trig_match_bank_chk #(
    .NUM_TRIG (NUM_TRIG),
    .ACT_W    (trig_pkg::ACT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_priv_i  (req_priv_i),
    .local_hit_o (local_hit_o),
    .trip_o      (trip_o),
    .act_vld_o   (act_vld_o),
    .act_o       (act_o)
);

// File: tb/tb_trig_match_bank.sv
// Scoreboard bench: a driver task predicts each result from the requirements
// and queues it; a monitor compares the registered outputs one clock later.
module tb_trig_match_bank;

    localparam int XLEN = 32;
    localparam int NT   = 4;
    localparam logic [XLEN-1:0] NMAX = 32'hBFFF_FFFF;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NT*XLEN-1:0]   cfg_ctrl_i = '0;
    logic [NT-1:0]        cmp_we_i = '0;
    logic [XLEN-1:0]      cmp_wdata_i = '0;
    logic                 req_valid_i = 1'b0;
    logic [1:0]           req_kind_i = 2'd0;
    logic [1:0]           req_priv_i = 2'd3;
    logic                 req_is_data_i = 1'b0;
    logic [XLEN-1:0]      req_item_i = '0;
    logic [NT-1:0]        local_hit_o;
    logic [NT-1:0]        trip_o;
    logic                 act_vld_o;
    logic [3:0]           act_o;

    always #4 clk = ~clk;

    trig_match_bank #(.XLEN(XLEN), .NUM_TRIG(NT), .NAPOT_MAX(NMAX)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl_i(cfg_ctrl_i), .cmp_we_i(cmp_we_i),
        .cmp_wdata_i(cmp_wdata_i), .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
        .req_priv_i(req_priv_i), .req_is_data_i(req_is_data_i), .req_item_i(req_item_i),
        .local_hit_o(local_hit_o), .trip_o(trip_o), .act_vld_o(act_vld_o), .act_o(act_o)
    );

    typedef struct {
        logic [NT-1:0] lh;
        logic [NT-1:0] tr;
        logic          vld;
        logic [3:0]    act;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [XLEN-1:0] m_ctrl [NT];
    logic [XLEN-1:0] m_cv   [NT];

    // Build a control word from named fields.
    function automatic logic [XLEN-1:0] mk(input int typ, input int code, input bit ld,
        input bit st, input bit ex, input bit u, input bit s, input bit m,
        input bit sel, input bit ch, input int act);
        logic [XLEN-1:0] w;
        w = '0;
        w[0] = ld; w[1] = st; w[2] = ex; w[3] = u; w[4] = s; w[6] = m;
        w[10:7] = code[3:0]; w[11] = ch; w[15:12] = act[3:0];
        if (typ == 6) w[21] = sel; else w[19] = sel;
        w[31:28] = typ[3:0];
        return w;
    endfunction

    function automatic logic [XLEN-1:0] m_mask(input logic [XLEN-1:0] v);
        int t;
        t = 0;
        while (t < XLEN && v[t]) t++;
        if (t >= XLEN - 1) return '0;
        return {XLEN{1'b1}} << (t + 1);
    endfunction

    // Requirement-level model of one trigger's local hit.
    function automatic bit m_hit(input int i, input logic [XLEN-1:0] it, input int kind,
        input int priv, input bit isd);
        logic [XLEN-1:0] c, v, mk_;
        int typ, code;
        bit en, r, sel;
        c = m_ctrl[i]; v = m_cv[i]; mk_ = m_mask(v);
        typ = int'(c[31:28]); code = int'(c[10:7]);
        if (typ != 2 && typ != 6) return 0;
        sel = (typ == 6) ? c[21] : c[19];
        if (sel != isd) return 0;
        en = (kind == 0) ? c[0] : (kind == 1) ? c[1] : (kind == 2) ? c[2] : 1'b0;
        if (!en) return 0;
        en = (priv == 0) ? c[3] : (priv == 1) ? c[4] : (priv == 3) ? c[6] : 1'b0;
        if (!en) return 0;
        case (code % 8)
            0: r = (it == v);
            1: r = ((it & mk_) == (v & mk_));
            2: r = (it >= v);
            3: r = (it < v);
            4: r = ((it[15:0] & v[31:16]) == v[15:0]);
            5: r = ((it[31:16] & v[31:16]) == v[15:0]);
            default: return 0;
        endcase
        if (code >= 8) begin
            if (code == 10 || code == 11 || code == 14 || code == 15) return 0;
            r = !r;
        end
        return r;
    endfunction

    task automatic set_ctrl(input int i, input logic [XLEN-1:0] w);
        @(negedge clk);
        req_valid_i = 1'b0;
        m_ctrl[i] = w;
        cfg_ctrl_i[i*XLEN +: XLEN] = w;
    endtask

    task automatic wr_cmp(input int i, input logic [XLEN-1:0] v);
        @(negedge clk);
        req_valid_i = 1'b0;
        cmp_we_i = '0; cmp_we_i[i] = 1'b1; cmp_wdata_i = v;
        m_cv[i] = (m_ctrl[i][31:28] == 4'd6 && v == '1) ? NMAX : v;
        @(negedge clk);
        cmp_we_i = '0;
    endtask

    // Drive one request and queue the predicted result.
    task automatic present(input logic [XLEN-1:0] it, input int kind, input int priv,
        input bit isd, input bit vld, input string tag);
        exp_t e;
        int s, en;
        bit all;
        @(negedge clk);
        req_valid_i = vld; req_item_i = it; req_kind_i = kind[1:0];
        req_priv_i = priv[1:0]; req_is_data_i = isd;
        e.lh = '0; e.tr = '0; e.vld = 0; e.act = '0; e.tag = tag;
        if (vld) for (int i = 0; i < NT; i++) e.lh[i] = m_hit(i, it, kind, priv, isd);
        s = 0;
        while (s < NT) begin
            en = s;
            while (en < NT - 1 && m_ctrl[en][11]) en++;
            all = 1;
            for (int k = s; k <= en; k++) all = all & e.lh[k];
            if (all) begin
                for (int k = s; k <= en; k++) e.tr[k] = 1'b1;
                if (!e.vld) begin e.vld = 1; e.act = m_ctrl[en][15:12]; end
            end
            s = en + 1;
        end
        exp_q.push_back(e);
    endtask

    // Monitor: compare registered outputs after the capturing edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (local_hit_o !== e.lh || trip_o !== e.tr || act_vld_o !== e.vld ||
                (e.vld && act_o !== e.act)) begin
                errors++;
                $display("FAIL %s: got lh=%b tr=%b vld=%b act=%0d exp lh=%b tr=%b vld=%b act=%0d",
                    e.tag, local_hit_o, trip_o, act_vld_o, act_o, e.lh, e.tr, e.vld, e.act);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) begin m_ctrl[i] = mk(15,0,0,0,0,0,0,0,0,0,0); m_cv[i] = '0; end
        cfg_ctrl_i = {NT{mk(15,0,0,0,0,0,0,0,0,0,0)}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (local_hit_o !== '0 || trip_o !== '0 || act_vld_o !== 1'b0 || act_o !== '0) begin
            errors++;
            $display("FAIL R1: got lh=%b tr=%b vld=%b act=%0d exp all zero",
                local_hit_o, trip_o, act_vld_o, act_o);
        end
        // R1: reset compare value 0 with mask ignoring bit 0
        set_ctrl(0, mk(2,1,1,0,0,0,0,1,0,0,0));
        present(32'h0000_0001, 0, 3, 0, 1, "R1");
        present(32'h0000_0002, 0, 3, 0, 1, "R1");

        // R2: equality and inequality
        set_ctrl(0, mk(2,0,1,0,0,0,0,1,0,0,0));
        wr_cmp(0, 32'h0000_1000);
        present(32'h0000_1000, 0, 3, 0, 1, "R2");
        present(32'h0000_1004, 0, 3, 0, 1, "R2");
        set_ctrl(0, mk(2,8,1,0,0,0,0,1,0,0,0));
        present(32'h0000_1004, 0, 3, 0, 1, "R2");
        present(32'h0000_1000, 0, 3, 0, 1, "R2");

        // R3: NAPOT masked compare and its negation
        set_ctrl(0, mk(2,1,1,0,0,0,0,1,0,0,0));
        wr_cmp(0, 32'h0000_10FF);
        present(32'h0000_11FF, 0, 3, 0, 1, "R3");
        present(32'h0000_1000, 0, 3, 0, 1, "R3");
        present(32'h0000_1200, 0, 3, 0, 1, "R3");
        set_ctrl(0, mk(2,9,1,0,0,0,0,1,0,0,0));
        present(32'h0000_1200, 0, 3, 0, 1, "R3");
        present(32'h0000_11AB, 0, 3, 0, 1, "R3");

        // R4: zero mask matches everything
        set_ctrl(0, mk(2,1,1,0,0,0,0,1,0,0,0));
        wr_cmp(0, 32'h7FFF_FFFF);
        present(32'h8000_0000, 0, 3, 0, 1, "R4");
        present(32'h0000_0000, 0, 3, 0, 1, "R4");
        wr_cmp(0, 32'hFFFF_FFFF);
        present(32'h1234_5678, 0, 3, 0, 1, "R4");

        // R5: unsigned ordering
        set_ctrl(0, mk(2,2,1,0,0,0,0,1,0,0,0));
        wr_cmp(0, 32'h8000_0000);
        present(32'h7FFF_FFFF, 0, 3, 0, 1, "R5");
        present(32'h9000_0000, 0, 3, 0, 1, "R5");
        present(32'h8000_0000, 0, 3, 0, 1, "R5");
        set_ctrl(0, mk(2,3,1,0,0,0,0,1,0,0,0));
        present(32'h7FFF_FFFF, 0, 3, 0, 1, "R5");
        present(32'h8000_0000, 0, 3, 0, 1, "R5");

        // R6: half-word modes and negations
        wr_cmp(0, 32'h00FF_0034);
        set_ctrl(0, mk(2,4,1,0,0,0,0,1,0,0,0));
        present(32'hABCD_1234, 0, 3, 0, 1, "R6");
        present(32'h1234_ABCD, 0, 3, 0, 1, "R6");
        set_ctrl(0, mk(2,5,1,0,0,0,0,1,0,0,0));
        present(32'h1234_ABCD, 0, 3, 0, 1, "R6");
        present(32'hABCD_1234, 0, 3, 0, 1, "R6");
        set_ctrl(0, mk(2,12,1,0,0,0,0,1,0,0,0));
        present(32'h1234_ABCD, 0, 3, 0, 1, "R6");
        set_ctrl(0, mk(2,13,1,0,0,0,0,1,0,0,0));
        present(32'h1234_ABCD, 0, 3, 0, 1, "R6");

        // R14: undefined codes never hit
        wr_cmp(0, 32'h0000_5555);
        set_ctrl(0, mk(2,6,1,0,0,0,0,1,0,0,0));
        present(32'h0000_5555, 0, 3, 0, 1, "R14");
        set_ctrl(0, mk(2,10,1,0,0,0,0,1,0,0,0));
        present(32'h0000_0000, 0, 3, 0, 1, "R14");
        set_ctrl(0, mk(2,15,1,0,0,0,0,1,0,0,0));
        present(32'h0000_0000, 0, 3, 0, 1, "R14");

        // R7: access kind and select gating
        set_ctrl(0, mk(2,0,1,0,0,0,0,1,0,0,0));
        present(32'h0000_5555, 1, 3, 0, 1, "R7");
        present(32'h0000_5555, 2, 3, 0, 1, "R7");
        present(32'h0000_5555, 3, 3, 0, 1, "R7");
        present(32'h0000_5555, 0, 3, 1, 1, "R7");
        set_ctrl(0, mk(2,0,0,1,1,0,0,1,1,0,0));
        present(32'h0000_5555, 1, 3, 1, 1, "R7");
        present(32'h0000_5555, 2, 3, 1, 1, "R7");
        present(32'h0000_5555, 1, 3, 0, 1, "R7");

        // R8: privilege gating
        set_ctrl(0, mk(2,0,1,0,0,1,0,0,0,0,0));
        present(32'h0000_5555, 0, 0, 0, 1, "R8");
        present(32'h0000_5555, 0, 3, 0, 1, "R8");
        present(32'h0000_5555, 0, 2, 0, 1, "R8");
        set_ctrl(0, mk(2,0,1,0,0,0,1,0,0,0,0));
        present(32'h0000_5555, 0, 1, 0, 1, "R8");

        // R9: disabled and foreign types
        set_ctrl(0, mk(0,0,1,0,0,1,1,1,0,0,0));
        present(32'h0000_5555, 0, 3, 0, 1, "R9");
        set_ctrl(0, mk(15,0,1,0,0,1,1,1,0,0,0));
        present(32'h0000_5555, 0, 3, 0, 1, "R9");
        set_ctrl(0, mk(3,0,1,0,0,1,1,1,0,0,0));
        present(32'h0000_5555, 0, 3, 0, 1, "R9");

        // R12: all-ones substitution for type 6 only
        set_ctrl(1, mk(6,1,1,0,0,0,0,1,0,0,0));
        wr_cmp(1, 32'hFFFF_FFFF);
        present(32'h0000_0000, 0, 3, 0, 1, "R12");
        present(32'h8000_0000, 0, 3, 0, 1, "R12");
        set_ctrl(1, mk(6,0,1,0,0,0,0,1,0,0,0));
        present(32'hBFFF_FFFF, 0, 3, 0, 1, "R12");

        // R10/R11: chains
        set_ctrl(1, mk(15,0,0,0,0,0,0,0,0,0,0));
        wr_cmp(0, 32'h0000_0100);
        wr_cmp(1, 32'h0000_0200);
        wr_cmp(2, 32'h0000_0100);
        wr_cmp(3, 32'h0000_0100);
        set_ctrl(0, mk(2,2,1,0,0,0,0,1,0,1,3));
        set_ctrl(1, mk(2,3,1,0,0,0,0,1,0,0,5));
        set_ctrl(2, mk(2,0,1,0,0,0,0,1,0,0,7));
        set_ctrl(3, mk(2,8,1,0,0,0,0,1,0,1,9));
        present(32'h0000_0180, 0, 3, 0, 1, "R10");
        present(32'h0000_0080, 0, 3, 0, 1, "R10");
        present(32'h0000_0280, 0, 3, 0, 1, "R10");
        present(32'h0000_0100, 0, 3, 0, 1, "R11");
        present(32'h0000_0300, 0, 3, 0, 1, "R11");
        set_ctrl(3, mk(2,0,1,0,0,0,0,1,0,1,9));
        set_ctrl(2, mk(2,0,1,0,0,0,0,1,0,1,7));
        present(32'h0000_0100, 0, 3, 0, 1, "R11");
        present(32'h0000_0100, 0, 3, 0, 0, "R13");
        present(32'h0000_0180, 0, 3, 0, 1, "R13");

        @(negedge clk);
        req_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule